// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a synchronous DRAM command bus and follows it cycle by cycle. For every bank it keeps whether the bank is idle or holds an open row, which row is open, and whether a burst with automatic close is still running on it. Commands are taken from the chip-select, row-strobe, column-strobe and write-enable lines. The bank-address lines and address bit 10 select which bank or banks a command targets.

A command that breaks the open-row rules or arrives too early is reported and has no effect. This covers a command that arrives inside the precharge recovery window or the mode-load recovery window. Each such command raises a one-cycle error strobe with a reason code and the bank at fault. The recovery windows and the reset burst setting are parameters. The burst length is taken from each accepted mode-register load and decides when an automatic close completes.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While cs_ni is high no command is accepted whatever ras_ni, cas_ni and we_ni show; no error is raised and no bank state changes, though a running automatic close still completes.
- R2: With cs_ni low, the encoding {ras_ni,cas_ni,we_ni} selects 011 activate, 101 read, 100 write, 010 precharge, 000 mode load and 111 no-op; a no-op changes no bank state and raises no error.
- R3: An activate to an idle, recovered bank sets bank_active_o for the bank given by ba_i, and its open_row_o slice shows addr_i, from the clock edge that samples the command.
- R4: An activate to a bank that already has an open row raises error code 0 (bank not idle) with that bank, and the open row is kept.
- R5: A read or write to an idle bank raises error code 1 (bank not active) with that bank.
- R6: A read or write with addr_i[10] high, under a burst length BL that is not full page, sets ap_pending_o for the bank at the command edge. Exactly BL edges later ap_pending_o clears, the bank goes idle and its row reads 0. With addr_i[10] low the row stays open, and the choice holds for that one command only.
- R7: When the latched burst code is 7 (full page), addr_i[10] on a read or write is ignored: no close is scheduled and the row stays open.
- R8: A precharge with addr_i[10] low closes only bank ba_i. With addr_i[10] high it closes every open bank and ignores ba_i.
- R9: Suppose a bank is closed at edge k, explicitly or automatically. Any command aimed at it at edges k+1 to k+T_RP-1 raises error code 3 (timing). The same applies to any command aimed at a bank with an automatic close pending, and to a precharge-all or mode load while any bank is recovering.
- R10: A mode load while any bank is open raises error code 2 with the lowest-numbered open bank. An accepted mode load latches addr_i[2:0] as the burst code, where codes 0 to 3 give bursts of 1, 2, 4 and 8 and code 7 is full page.
- R11: An activate, read, write, precharge or mode load at edges k+1 to k+T_MRD-1 after a mode load accepted at edge k raises error code 3 with bank ba_i.
- R12: err_o is high for one cycle per faulty command, and the faulty command changes no state. err_code_o and err_bank_o read 0 whenever err_o is low.
- R13: After reset all banks are idle with row 0, nothing is pending, err_o is low and the burst code is BURST_RST (default 2, a burst of 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ROW_W | Row / column / mode address; bit AP_BIT selects close option |
| bank_active_o | output | NUM_BANKS | One bit per bank, high while a row is open |
| open_row_o | output | NUM_BANKS*ROW_W | Open row per bank, bank b at slice b*ROW_W |
| ap_pending_o | output | NUM_BANKS | Automatic close scheduled per bank |
| err_o | output | 1 | One-cycle error strobe |
| err_code_o | output | 2 | 0 not idle, 1 not active, 2 mode load while open, 3 timing |
| err_bank_o | output | BA_W | Bank at fault |

## Verification
An automatic close can complete in the same cycle that a different command is accepted. The bench provokes this by issuing an activate to one bank on exactly the edge where another bank's write burst with close ends, and it expects both effects in one step: the closing bank goes idle and the new bank opens. A command to the closing bank in the cycle before must be refused as a timing error. The tRP count that starts at that edge must then refuse a second activate and accept a third.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_INHIBIT,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_LMR,
    CMD_OTHER
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NOT_IDLE   = 2'd0,
    ERR_NOT_ACTIVE = 2'd1,
    ERR_MODE_OPEN  = 2'd2,
    ERR_TIMING     = 2'd3
  } err_e;

  localparam logic [2:0] BL_FULL_PAGE = 3'd7;
  localparam int unsigned BLEN_W = 4;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_INHIBIT;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_LMR;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sbt_recovery_timer.sv
module sbt_recovery_timer #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int unsigned ROW_W = 13,
  parameter int unsigned T_RP  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              close_i,
  input  logic              ap_start_i,
  input  logic [BLEN_W-1:0] ap_len_i,
  output logic              active_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              ap_pend_o,
  output logic              busy_o
);

  logic [BLEN_W-1:0] ap_cnt_q;
  logic              ap_done;
  logic              rp_busy;

  // burst end: last count before zero
  assign ap_done = (ap_cnt_q == BLEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (open_i) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (close_i || ap_done) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_cnt_q <= '0;
    end else if (ap_start_i) begin
      ap_cnt_q <= ap_len_i;
    end else if (ap_cnt_q != '0) begin
      ap_cnt_q <= ap_cnt_q - 1'b1;
    end
  end

  sbt_recovery_timer #(
    .CYCLES(T_RP)
  ) u_rp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (close_i | ap_done),
    .busy_o (rp_busy)
  );

  assign ap_pend_o = (ap_cnt_q != '0);
  assign busy_o    = rp_busy | ap_pend_o;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_MRD     = 2,
  parameter logic [2:0]  BURST_RST = 3'd2,
  localparam int unsigned BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [NUM_BANKS-1:0]       ap_pending_o,
  output logic                       err_o,
  output logic [1:0]                 err_code_o,
  output logic [BA_W-1:0]            err_bank_o
);

  cmd_e                  cmd;
  logic [NUM_BANKS-1:0]  busy;
  logic [NUM_BANKS-1:0]  open_v, close_v, ap_v;
  logic                  mrd_busy, mrd_load;
  logic [2:0]            bl_code_q;
  logic [BLEN_W-1:0]     bl_len;
  logic                  ap_req;
  logic [BA_W-1:0]       low_busy, low_open;
  logic                  err_d;
  err_e                  code_d;
  logic [BA_W-1:0]       bank_d;

  sbt_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sbt_bank #(
      .ROW_W (ROW_W),
      .T_RP  (T_RP)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .open_i     (open_v[b]),
      .row_i      (addr_i),
      .close_i    (close_v[b]),
      .ap_start_i (ap_v[b]),
      .ap_len_i   (bl_len),
      .active_o   (bank_active_o[b]),
      .row_o      (open_row_o[b*ROW_W +: ROW_W]),
      .ap_pend_o  (ap_pending_o[b]),
      .busy_o     (busy[b])
    );
  end

  sbt_recovery_timer #(
    .CYCLES(T_MRD)
  ) u_mrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mrd_load),
    .busy_o (mrd_busy)
  );

  assign bl_len = BLEN_W'(1) << bl_code_q[1:0];
  assign ap_req = addr_i[AP_BIT] && (bl_code_q != BL_FULL_PAGE);

  // lowest-numbered bank wins
  always_comb begin
    low_busy = '0;
    low_open = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (busy[i])          low_busy = BA_W'(i);
      if (bank_active_o[i]) low_open = BA_W'(i);
    end
  end

  always_comb begin
    open_v   = '0;
    close_v  = '0;
    ap_v     = '0;
    mrd_load = 1'b0;
    err_d    = 1'b0;
    code_d   = ERR_TIMING;
    bank_d   = ba_i;
    if (mrd_busy && (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_LMR})) begin
      err_d = 1'b1;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (busy[ba_i]) begin
            err_d = 1'b1;
          end else if (bank_active_o[ba_i]) begin
            err_d  = 1'b1;
            code_d = ERR_NOT_IDLE;
          end else begin
            open_v[ba_i] = 1'b1;
          end
        end
        CMD_RD, CMD_WR: begin
          if (busy[ba_i]) begin
            err_d = 1'b1;
          end else if (!bank_active_o[ba_i]) begin
            err_d  = 1'b1;
            code_d = ERR_NOT_ACTIVE;
          end else begin
            ap_v[ba_i] = ap_req;
          end
        end
        CMD_PRE: begin
          if (addr_i[AP_BIT]) begin
            if (|busy) begin
              err_d  = 1'b1;
              bank_d = low_busy;
            end else begin
              close_v = bank_active_o;
            end
          end else if (busy[ba_i]) begin
            err_d = 1'b1;
          end else begin
            close_v[ba_i] = bank_active_o[ba_i];
          end
        end
        CMD_LMR: begin
          if (|busy) begin
            err_d  = 1'b1;
            bank_d = low_busy;
          end else if (|bank_active_o) begin
            err_d  = 1'b1;
            code_d = ERR_MODE_OPEN;
            bank_d = low_open;
          end else begin
            mrd_load = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_code_q <= BURST_RST;
    end else if (mrd_load) begin
      bl_code_q <= addr_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= '0;
      err_bank_o <= '0;
    end else begin
      err_o      <= err_d;
      err_code_o <= err_d ? code_d : 2'd0;
      err_bank_o <= err_d ? bank_d : '0;
    end
  end

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned BA_W      = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       ras_ni,
  input logic                       cas_ni,
  input logic                       we_ni,
  input logic [BA_W-1:0]            ba_i,
  input logic [ROW_W-1:0]           addr_i,
  input logic [NUM_BANKS-1:0]       bank_active_o,
  input logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  input logic [NUM_BANKS-1:0]       ap_pending_o,
  input logic                       err_o,
  input logic [1:0]                 err_code_o,
  input logic [BA_W-1:0]            err_bank_o
);

  logic is_nop, is_act, is_rw, is_pre_all;
  assign is_nop     = !cs_ni && ras_ni && cas_ni && we_ni;
  assign is_act     = !cs_ni && !ras_ni && cas_ni && we_ni;
  assign is_rw      = !cs_ni && ras_ni && !cas_ni;
  assign is_pre_all = !cs_ni && !ras_ni && cas_ni && !we_ni && addr_i[AP_BIT];

  a_r1_inhibit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && (ap_pending_o == '0) |=> !err_o && $stable(bank_active_o) && $stable(open_row_o));

  a_r2_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_nop && (ap_pending_o == '0) |=> !err_o && $stable(bank_active_o) && $stable(open_row_o));

  a_r3_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act && !bank_active_o[ba_i] |=> bank_active_o[$past(ba_i)] || err_o);

  a_r4_act_open_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act && bank_active_o[ba_i] |=> err_o);

  a_r5_access_idle_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw && !bank_active_o[ba_i] |=> err_o);

  a_r8_pre_all_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre_all |=> (bank_active_o == '0) || err_o);

  a_r12_err_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && ($past(ap_pending_o) == '0) |-> bank_active_o == $past(bank_active_o));

  a_r12_fields_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (err_code_o == 2'd0) && (err_bank_o == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
    a_r6_close_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ap_pending_o[b]) |-> !bank_active_o[b]);
  end

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .AP_BIT    (AP_BIT),
  .BA_W      (BA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .ras_ni        (ras_ni),
  .cas_ni        (cas_ni),
  .we_ni         (we_ni),
  .ba_i          (ba_i),
  .addr_i        (addr_i),
  .bank_active_o (bank_active_o),
  .open_row_o    (open_row_o),
  .ap_pending_o  (ap_pending_o),
  .err_o         (err_o),
  .err_code_o    (err_code_o),
  .err_bank_o    (err_bank_o)
);

// File: tb/sdram_bank_tracker_test.sv
`timescale 1ns/1ps
module sdram_bank_tracker_test;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_INH = 4'b1011;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef struct {
    logic [3:0]  act;
    logic [3:0]  ap;
    logic        err;
    logic [1:0]  code;
    logic [1:0]  bank;
    bit          chk_row;
    int          rbank;
    logic [12:0] row;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_active;
  logic [51:0] open_row;
  logic [3:0]  ap_pending;
  logic        err;
  logic [1:0]  err_code;
  logic [1:0]  err_bank;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  sdram_bank_tracker uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cs_ni         (cs_ni),
    .ras_ni        (ras_ni),
    .cas_ni        (cas_ni),
    .we_ni         (we_ni),
    .ba_i          (ba),
    .addr_i        (addr),
    .bank_active_o (bank_active),
    .open_row_o    (open_row),
    .ap_pending_o  (ap_pending),
    .err_o         (err),
    .err_code_o    (err_code),
    .err_bank_o    (err_bank)
  );

  task automatic step(input logic [3:0] ctl, input logic [1:0] b, input logic [12:0] a,
                      input logic [3:0] e_act, input logic [3:0] e_ap,
                      input logic e_err, input logic [1:0] e_code, input logic [1:0] e_bank,
                      input bit chk_row, input int rbank, input logic [12:0] row,
                      input string tag);
    exp_t it;
    @(negedge clk);
    {cs_ni, ras_ni, cas_ni, we_ni} = ctl;
    ba   = b;
    addr = a;
    it.act = e_act; it.ap = e_ap; it.err = e_err; it.code = e_code; it.bank = e_bank;
    it.chk_row = chk_row; it.rbank = rbank; it.row = row; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic simple(input logic [3:0] ctl, input logic [1:0] b, input logic [12:0] a,
                        input logic [3:0] e_act, input logic [3:0] e_ap, input string tag);
    step(ctl, b, a, e_act, e_ap, 1'b0, 2'd0, 2'd0, 1'b0, 0, '0, tag);
  endtask

  task automatic bad(input logic [3:0] ctl, input logic [1:0] b, input logic [12:0] a,
                     input logic [3:0] e_act, input logic [3:0] e_ap,
                     input logic [1:0] e_code, input logic [1:0] e_bank, input string tag);
    step(ctl, b, a, e_act, e_ap, 1'b1, e_code, e_bank, 1'b0, 0, '0, tag);
  endtask

  // monitor: pops one expected item per edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (bank_active !== it.act) begin
          failures++;
          $display("FAIL %s bank_active actual=%b expected=%b", it.tag, bank_active, it.act);
        end
        checks++;
        if (ap_pending !== it.ap) begin
          failures++;
          $display("FAIL %s ap_pending actual=%b expected=%b", it.tag, ap_pending, it.ap);
        end
        checks++;
        if (err !== it.err || (it.err && (err_code !== it.code || err_bank !== it.bank))) begin
          failures++;
          $display("FAIL %s err/code/bank actual=%b/%0d/%0d expected=%b/%0d/%0d",
                   it.tag, err, err_code, err_bank, it.err, it.code, it.bank);
        end
        if (it.chk_row) begin
          checks++;
          if (open_row[it.rbank*13 +: 13] !== it.row) begin
            failures++;
            $display("FAIL %s row[%0d] actual=%h expected=%h", it.tag, it.rbank,
                     open_row[it.rbank*13 +: 13], it.row);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(C_NOP, 0, 13'h0,    4'b0000, 4'b0000, 0, 0, 0, 1, 0, 13'h0,    "R13 reset state");
    step(C_ACT, 0, 13'h123,  4'b0001, 4'b0000, 0, 0, 0, 1, 0, 13'h123,  "R3 open bank0");
    step(C_ACT, 2, 13'h1ABC, 4'b0101, 4'b0000, 0, 0, 0, 1, 2, 13'h1ABC, "R3 open bank2");
    step(C_ACT, 0, 13'h005,  4'b0101, 4'b0000, 1, 0, 0, 1, 0, 13'h123,  "R4 R12 activate open bank");
    bad (C_RD,  1, 13'h0,    4'b0101, 4'b0000, 2'd1, 2'd1,              "R5 read idle bank");
    step(C_INH, 1, 13'h7,    4'b0101, 4'b0000, 0, 0, 0, 1, 1, 13'h0,    "R1 inhibit ignored");
    simple(C_NOP, 0, 13'h0,   4'b0101, 4'b0000,                          "R2 R12 nop after error");
    simple(C_RD,  0, 13'h0,   4'b0101, 4'b0000,                          "R6 read A10 low keeps row");
    simple(C_WR,  2, 13'h400, 4'b0101, 4'b0100,                          "R6 R13 write with close BL4");
    simple(C_NOP, 0, 13'h0,   4'b0101, 4'b0100,                          "R6 close pending");
    simple(C_ACT, 1, 13'h007, 4'b0111, 4'b0100,                          "R3 R6 open bank1 while pending");
    bad (C_RD,  2, 13'h0,    4'b0111, 4'b0100, 2'd3, 2'd2,              "R9 access during pending close");
    step(C_ACT, 3, 13'h009,  4'b1011, 4'b0000, 0, 0, 0, 1, 2, 13'h0,    "R6 close ends with activate bank3");
    bad (C_ACT, 2, 13'h001,  4'b1011, 4'b0000, 2'd3, 2'd2,              "R9 activate inside tRP");
    simple(C_NOP, 0, 13'h0,   4'b1011, 4'b0000,                          "R9 wait");
    step(C_ACT, 2, 13'h055,  4'b1111, 4'b0000, 0, 0, 0, 1, 2, 13'h055,  "R9 activate after tRP");
    simple(C_PRE, 1, 13'h0,   4'b1101, 4'b0000,                          "R8 precharge one bank");
    bad (C_RD,  1, 13'h0,    4'b1101, 4'b0000, 2'd3, 2'd1,              "R9 read inside tRP");
    simple(C_NOP, 0, 13'h0,   4'b1101, 4'b0000,                          "R9 wait");
    bad (C_LMR, 0, 13'h7,    4'b1101, 4'b0000, 2'd2, 2'd0,              "R10 mode load while open");
    simple(C_PRE, 2, 13'h400, 4'b0000, 4'b0000,                          "R8 precharge all");
    simple(C_NOP, 0, 13'h0,   4'b0000, 4'b0000,                          "R9 wait");
    simple(C_NOP, 0, 13'h0,   4'b0000, 4'b0000,                          "R9 wait");
    simple(C_LMR, 0, 13'h7,   4'b0000, 4'b0000,                          "R10 mode load full page");
    bad (C_ACT, 1, 13'h3,    4'b0000, 4'b0000, 2'd3, 2'd1,              "R11 command inside tMRD");
    simple(C_ACT, 1, 13'h3,   4'b0010, 4'b0000,                          "R11 command after tMRD");
    simple(C_RD,  1, 13'h400, 4'b0010, 4'b0000,                          "R7 A10 ignored full page");
    simple(C_NOP, 0, 13'h0,   4'b0010, 4'b0000,                          "R7 row stays open");
    simple(C_PRE, 0, 13'h400, 4'b0000, 4'b0000,                          "R8 precharge all");
    simple(C_NOP, 0, 13'h0,   4'b0000, 4'b0000,                          "R9 wait");
    simple(C_NOP, 0, 13'h0,   4'b0000, 4'b0000,                          "R9 wait");
    simple(C_LMR, 0, 13'h0,   4'b0000, 4'b0000,                          "R10 mode load burst 1");
    simple(C_NOP, 0, 13'h0,   4'b0000, 4'b0000,                          "R11 wait");
    simple(C_ACT, 3, 13'h2,   4'b1000, 4'b0000,                          "R3 open bank3");
    simple(C_WR,  3, 13'h400, 4'b1000, 4'b1000,                          "R6 R10 write with close BL1");
    step(C_NOP, 0, 13'h0,    4'b0000, 4'b0000, 0, 0, 0, 1, 3, 13'h0,    "R6 R10 closed after one edge");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule